// File: doc/BRIEF.md
# Auto-Baud Bit-Period Meter

This block measures the bit period on an asynchronous serial receive line so that a receiver can be set to an unknown sender's rate. Software arms the meter. The sender then transmits a synchronisation character of alternating bits (0x55, least significant bit first, framed by a low start bit and a high stop bit). That character puts five rising edges on the line. The meter starts counting at the first rising edge, which ends the start bit. It counts one tick every eight system clocks and stops at the fifth rising edge. It then loads the count into the divisor register, drops the armed status and raises the receive flag.

The line first passes through a two-flop synchroniser, and edges are detected on the synchronised copy. If the tick counter runs past the largest divisor value, a sticky overflow flag is raised. The counter keeps running and the meter still waits for the fifth edge, then loads a saturated all-ones divisor. Software can abort a measurement by clearing the armed status. A clear of the overflow flag only takes effect once the meter is no longer armed.

Top module: `baud_sense`

## Requirements
- R1: After reset, divisor is 0 and armed, ovf and rx_flag are 0.
- R2: A cycle with arm_set high makes armed 1 in the next cycle. A cycle with arm_clr high makes armed 0 in the next cycle. When both are high in the same cycle, arm_clr wins.
- R3: With 2^PRE_LOG2 clocks per tick, let D be the number of clocks between the first and the fifth synchronised rising edge after arming. The loaded divisor is floor((D-1)/2^PRE_LOG2). A 0x55 sync character sent at P clocks per bit therefore yields P-1.
- R4: The update on the fifth rising edge loads the divisor, clears armed and sets rx_flag, all in the same cycle.
- R5: A cycle with data_rd high clears rx_flag in the next cycle. A completion in the same cycle takes priority and sets it.
- R6: If the tick counter wraps past all ones while armed, ovf is set. The meter stays armed until the fifth edge, and then the divisor is loaded as all ones.
- R7: ovf stays set until an ovf_clr arrives in a cycle in which armed is 0. An ovf_clr issued while armed, including one in the same cycle as arm_clr, is ignored.
- R8: Rising edges seen while not armed, and a measurement aborted by arm_clr, leave the divisor and rx_flag unchanged.
- R9: An arm_set during a measurement restarts it from zero edges and a zero count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous receive line, idle high |
| arm_set | input | 1 | Strobe that arms (or re-arms) a measurement |
| arm_clr | input | 1 | Software clear of the armed status |
| ovf_clr | input | 1 | Software clear of the overflow flag |
| data_rd | input | 1 | Receive-data read strobe; clears rx_flag |
| divisor | output | DIV_W | Measured baud divisor |
| armed | output | 1 | A measurement is in progress |
| ovf | output | 1 | Sticky counter-overflow flag |
| rx_flag | output | 1 | Receive interrupt flag, raised on completion |

## Verification
The bench overrides DIV_W to 10, so an overflow occurs after a few thousand clocks. A design that cleared the overflow flag while armed, or that honoured a clear issued in the same cycle as the abort, would drop ovf early in the abort sequence. A design that stopped at overflow, or that loaded the wrapped count, would finish before the fifth slow edge or report a small divisor instead of all ones. A design that miscounted edges, started at arming instead of at the first rise, or kept stale edges across a re-arm would be off by whole bit periods in the divisor for sync characters at 5, 12, 16, 37 and 100 clocks per bit. Edges sent while not armed or after an abort must leave the divisor and the flag untouched.

// File: rtl/bs_pkg.sv
package bs_pkg;

    // Number of rising edges that bracket one measurement
    localparam int EDGE_TARGET = 5;
    localparam int EDGE_W      = $clog2(EDGE_TARGET + 1);
    localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(EDGE_TARGET - 1);

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // not armed
        PH_FIRST = 2'd1,   // armed, waiting for the edge that ends the start bit
        PH_COUNT = 2'd2    // counting ticks between edges
    } meas_phase_e;

    // Synchroniser and edge-detect pipeline for the receive line
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } rx_pipe_t;

    localparam rx_pipe_t RX_PIPE_IDLE = '{meta: 1'b1, sync: 1'b1, prev: 1'b1};

endpackage

// File: rtl/bs_edge_sync.sv
module bs_edge_sync
    import bs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);

    rx_pipe_t pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= RX_PIPE_IDLE;
        end else begin
            pipe_q.meta <= din;
            pipe_q.sync <= pipe_q.meta;
            pipe_q.prev <= pipe_q.sync;
        end
    end

    assign rise = pipe_q.sync & ~pipe_q.prev;

endmodule

// File: rtl/bs_prescale.sv
module bs_prescale #(
    parameter int LOG2 = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic tick
);

    localparam logic [LOG2-1:0] TOP = '1;

    logic [LOG2-1:0] q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (en) begin
            q <= q + 1'b1;
        end
    end

    assign tick = en && (q == TOP);

endmodule

// File: rtl/bs_meas.sv
module bs_meas
    import bs_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             tick,
    input  logic             arm_set,
    input  logic             arm_clr,
    input  logic             ovf_clr,
    input  logic             data_rd,
    output logic             armed,
    output logic             count_en,
    output logic             pre_clr,
    output logic             ovf,
    output logic             rx_flag,
    output logic [DIV_W-1:0] divisor
);

    localparam logic [DIV_W-1:0] DIV_MAX = '1;

    meas_phase_e       phase_q;
    logic [EDGE_W-1:0] edges_q;
    logic [DIV_W-1:0]  cnt_q;
    logic              wrap_q;

    logic hold;
    logic first_rise;
    logic last_rise;
    logic wrap_now;

    // Software strobes pre-empt any measurement progress in their cycle
    assign hold       = !arm_clr && !arm_set;
    assign count_en   = (phase_q == PH_COUNT) && hold;
    assign first_rise = (phase_q == PH_FIRST) && hold && rise;
    assign last_rise  = count_en && rise && (edges_q == EDGE_LAST);
    assign wrap_now   = count_en && tick && (cnt_q == DIV_MAX);
    assign pre_clr    = arm_set || first_rise;
    assign armed      = (phase_q != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            edges_q <= '0;
            cnt_q   <= '0;
            wrap_q  <= 1'b0;
            ovf     <= 1'b0;
            rx_flag <= 1'b0;
            divisor <= '0;
        end else begin
            if (arm_clr) begin
                phase_q <= PH_IDLE;
            end else if (arm_set) begin
                phase_q <= PH_FIRST;
                edges_q <= '0;
                cnt_q   <= '0;
                wrap_q  <= 1'b0;
            end else if (first_rise) begin
                phase_q <= PH_COUNT;
                edges_q <= EDGE_W'(1);
                cnt_q   <= '0;
            end else if (count_en) begin
                if (tick) cnt_q <= cnt_q + 1'b1;
                if (wrap_now) wrap_q <= 1'b1;
                if (rise) begin
                    if (last_rise) phase_q <= PH_IDLE;
                    else           edges_q <= edges_q + 1'b1;
                end
            end

            if (last_rise) begin
                divisor <= (wrap_q || wrap_now) ? DIV_MAX : cnt_q;
            end

            if (wrap_now) begin
                ovf <= 1'b1;
            end else if (ovf_clr && (phase_q == PH_IDLE)) begin
                ovf <= 1'b0;
            end

            if (last_rise) begin
                rx_flag <= 1'b1;
            end else if (data_rd) begin
                rx_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/baud_sense.sv
module baud_sense
    import bs_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int PRE_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_in,
    input  logic             arm_set,
    input  logic             arm_clr,
    input  logic             ovf_clr,
    input  logic             data_rd,
    output logic [DIV_W-1:0] divisor,
    output logic             armed,
    output logic             ovf,
    output logic             rx_flag
);

    logic rise;
    logic tick;
    logic count_en;
    logic pre_clr;

    bs_edge_sync u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_in),
        .rise (rise)
    );

    bs_prescale #(.LOG2(PRE_LOG2)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (pre_clr),
        .en   (count_en),
        .tick (tick)
    );

    bs_meas #(.DIV_W(DIV_W)) u_meas (
        .clk      (clk),
        .rst      (rst),
        .rise     (rise),
        .tick     (tick),
        .arm_set  (arm_set),
        .arm_clr  (arm_clr),
        .ovf_clr  (ovf_clr),
        .data_rd  (data_rd),
        .armed    (armed),
        .count_en (count_en),
        .pre_clr  (pre_clr),
        .ovf      (ovf),
        .rx_flag  (rx_flag),
        .divisor  (divisor)
    );

endmodule

// File: rtl/baud_sense_chk.sv
module baud_sense_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             arm_set,
    input logic             arm_clr,
    input logic             ovf_clr,
    input logic             data_rd,
    input logic [DIV_W-1:0] divisor,
    input logic             armed,
    input logic             ovf,
    input logic             rx_flag
);

    AST_ARM_SET: assert property (@(posedge clk) disable iff (rst)
        arm_set && !arm_clr |=> armed);  // R2

    AST_ARM_CLR: assert property (@(posedge clk) disable iff (rst)
        arm_clr |=> !armed);  // R2

    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        $fell(armed) && !$past(arm_clr) |-> rx_flag);  // R4

    AST_FLAG_READ: assert property (@(posedge clk) disable iff (rst)
        rx_flag && data_rd && !armed |=> !rx_flag);  // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        armed && ovf |=> ovf);  // R7

    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !armed && ovf_clr |=> !ovf);  // R7

    AST_DIV_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(divisor) |-> $fell(armed) && !$past(arm_clr));  // R8

endmodule

bind baud_sense baud_sense_chk #(.DIV_W(DIV_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .arm_set (arm_set),
    .arm_clr (arm_clr),
    .ovf_clr (ovf_clr),
    .data_rd (data_rd),
    .divisor (divisor),
    .armed   (armed),
    .ovf     (ovf),
    .rx_flag (rx_flag)
);

// File: tb/baud_sense_test.sv
module baud_sense_test;

    localparam int DIV_W    = 10;
    localparam int PRE_LOG2 = 3;
    localparam int PRE      = 1 << PRE_LOG2;
    localparam int DMAX     = (1 << DIV_W) - 1;
    localparam int WRAP_LIM = PRE * (1 << DIV_W);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx_in = 1'b1;
    logic             arm_set = 1'b0;
    logic             arm_clr = 1'b0;
    logic             ovf_clr = 1'b0;
    logic             data_rd = 1'b0;
    logic [DIV_W-1:0] divisor;
    logic             armed;
    logic             ovf;
    logic             rx_flag;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    baud_sense #(.DIV_W(DIV_W), .PRE_LOG2(PRE_LOG2)) uut (
        .clk     (clk),
        .rst     (rst),
        .rx_in   (rx_in),
        .arm_set (arm_set),
        .arm_clr (arm_clr),
        .ovf_clr (ovf_clr),
        .data_rd (data_rd),
        .divisor (divisor),
        .armed   (armed),
        .ovf     (ovf),
        .rx_flag (rx_flag)
    );

    // ---------------- behavioural reference model ----------------
    bit m_q[$];          // raw line samples, newest at back
    bit m_sync_prev = 1, m_sync = 1;
    int m_div = 0;
    bit m_armed = 0, m_ovf = 0, m_flag = 0, m_wrapped = 0;
    int m_rises = 0;     // rises seen since arming
    int m_elapsed = 0;   // clocks since first rise

    always @(posedge clk) begin
        bit rise_now;
        bit wrap_now;
        bit fin;
        rise_now = m_sync && !m_sync_prev;
        wrap_now = 0;
        fin = 0;
        if (rst) begin
            m_q.delete();
            m_sync = 1; m_sync_prev = 1;
            m_div = 0; m_armed = 0; m_ovf = 0; m_flag = 0;
            m_wrapped = 0; m_rises = 0; m_elapsed = 0;
        end else begin
            m_sync_prev = m_sync;
            m_sync = (m_q.size() > 0) ? m_q[m_q.size()-1] : 1'b1;
            m_q.push_back(rx_in);
            if (m_q.size() > 2) void'(m_q.pop_front());
            if (ovf_clr && !m_armed) m_ovf = 0;
            if (arm_clr) begin
                m_armed = 0;
            end else if (arm_set) begin
                m_armed = 1; m_rises = 0; m_elapsed = 0; m_wrapped = 0;
            end else if (m_armed) begin
                if (m_rises >= 1) begin
                    if (m_elapsed + 1 >= WRAP_LIM) begin
                        wrap_now = 1; m_wrapped = 1; m_ovf = 1;
                    end
                    if (rise_now && m_rises == 4) begin
                        fin = 1;
                        m_div = m_wrapped ? DMAX : (m_elapsed / PRE);
                        m_armed = 0;
                    end else if (rise_now) begin
                        m_rises++;
                    end
                    m_elapsed++;
                end else if (rise_now) begin
                    m_rises = 1; m_elapsed = 0;
                end
            end
            if (fin) m_flag = 1;
            else if (data_rd) m_flag = 0;
            if (wrap_now) m_ovf = 1;
        end
    end

    task automatic check(input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check(int'(divisor), m_div,  "R3 model divisor");
            check(int'(armed),   m_armed, "R2 model armed");
            check(int'(ovf),     m_ovf,   "R7 model ovf");
            check(int'(rx_flag), m_flag,  "R5 model rx_flag");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_arm();
        arm_set = 1; wait_n(1); arm_set = 0;
    endtask

    task automatic do_read();
        data_rd = 1; wait_n(1); data_rd = 0;
    endtask

    task automatic do_ovf_clr();
        ovf_clr = 1; wait_n(1); ovf_clr = 0;
    endtask

    task automatic send_sync(input int p);
        bit [9:0] frame;
        frame = {1'b1, 8'h55, 1'b0};
        for (int i = 0; i < 10; i++) begin
            rx_in = frame[i];
            wait_n(p);
        end
        rx_in = 1;
        wait_n(6);
    endtask

    task automatic slow_edges(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            rx_in = 0; wait_n(gap);
            rx_in = 1; wait_n(gap);
        end
    endtask

    task automatic measure(input int p);
        do_arm();
        check(int'(armed), 1, "R2 armed after arm_set");
        send_sync(p);
        check(int'(divisor), p - 1, "R3 divisor equals bit period minus one");
        check(int'(armed), 0, "R4 armed cleared on fifth edge");
        check(int'(rx_flag), 1, "R4 rx_flag set on fifth edge");
        do_read();
        check(int'(rx_flag), 0, "R5 rx_flag cleared by read");
    endtask

    initial begin
        wait_n(5);
        rst = 0;
        wait_n(1);
        check(int'(divisor), 0, "R1 reset divisor");
        check(int'(armed),   0, "R1 reset armed");
        check(int'(ovf),     0, "R1 reset ovf");
        check(int'(rx_flag), 0, "R1 reset rx_flag");

        // R2: simultaneous set and clear, clear wins
        arm_set = 1; arm_clr = 1; wait_n(1); arm_set = 0; arm_clr = 0;
        check(int'(armed), 0, "R2 clear wins over set");

        measure(16);
        measure(37);
        measure(5);
        measure(100);

        // R8: edges while not armed leave state untouched
        send_sync(20);
        check(int'(divisor), 99, "R8 divisor unchanged when not armed");
        check(int'(rx_flag), 0, "R8 rx_flag unchanged when not armed");

        // R6: slow stream overflows, meter keeps waiting
        do_arm();
        slow_edges(3, 2500);
        check(int'(ovf), 1, "R6 ovf set after wrap");
        check(int'(armed), 1, "R6 still armed after wrap");
        do_ovf_clr();
        check(int'(ovf), 1, "R7 ovf_clr ignored while armed");
        slow_edges(2, 2500);
        check(int'(armed), 0, "R6 finished at fifth edge");
        check(int'(divisor), DMAX, "R6 divisor saturated");
        check(int'(rx_flag), 1, "R6 rx_flag after overflowed run");
        do_read();
        do_ovf_clr();
        check(int'(ovf), 0, "R7 ovf cleared when not armed");

        // Abort ordering
        measure(16);
        do_arm();
        slow_edges(3, 3000);
        check(int'(ovf), 1, "R7 ovf set before abort");
        arm_clr = 1; ovf_clr = 1; wait_n(1); arm_clr = 0; ovf_clr = 0;
        check(int'(armed), 0, "R2 abort clears armed");
        check(int'(ovf), 1, "R7 ovf_clr with arm_clr ignored");
        do_ovf_clr();
        check(int'(ovf), 0, "R7 ovf cleared after abort");
        slow_edges(2, 100);
        check(int'(divisor), 15, "R8 divisor unchanged after abort");
        check(int'(rx_flag), 0, "R8 rx_flag unchanged after abort");

        // R9: re-arm mid-measurement restarts
        do_arm();
        slow_edges(2, 7);
        measure(12);
        check(int'(divisor), 11, "R9 re-arm restarts measurement");

        wait_n(4);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule